// File: doc/BRIEF.md
# Comparator Output Conditioner

This block sits behind one analog comparator and turns its raw, unclocked decision bit into a clean clocked result. The raw bit is brought into the system clock domain through a two-stage synchronizer. It can then be inverted, which covers a configuration where the two analog inputs are exchanged. An optional majority-vote filter follows, with a choice of no vote, two of three samples, or three of five samples. The conditioned value is held in a state register. An edge detector on that register raises a one-clock interrupt pulse on the selected event.

The block runs in one of two modes. In continuous mode it samples on every clock and raises a ready flag once the synchronizer and filter window have filled after enable. In single-shot mode it holds its result until a start strobe arrives. It then clears the filter history and samples for exactly as many cycles as the synchronizer and window need. At that point it captures one result, raises ready and may issue an end-of-comparison pulse.

A route selector drives an external pin from the raw value, from the conditioned value, or holds it low. All settings are static inputs and are changed only while the block is disabled.

Top module: `cmp_out_cond`

## Requirements
- R1: After reset, with `en` low, `state_out`, `ready`, `irq_pulse` and `pin_out` are all 0.
- R2: With filter code 0 in continuous mode, a change on `raw_in` set up before clock edge k appears on `state_out` after edge k+2 and not before.
- R3: Filter code 1 is a 2-of-3 majority over the newest synchronized samples. A high pulse on `raw_in` one cycle long does not change `state_out`, and a lasting change appears after edge k+3.
- R4: Filter code 2 is a 3-of-5 majority. A high pulse on `raw_in` two cycles long does not change `state_out`, and a lasting change appears after edge k+4.
- R5: Filter codes 3 to 7 behave as code 0: there is no filtering, so a one-cycle glitch passes through.
- R6: With `invert` high, `state_out` settles to the complement of `raw_in`.
- R7: With `irq_sel` = 0, every change of `state_out` produces exactly one `irq_pulse` that lasts one clock.
- R8: `irq_sel` = 1 pulses only when `state_out` rises, and `irq_sel` = 2 pulses only when it falls.
- R9: `irq_sel` = 3 (end of comparison) never pulses in continuous mode.
- R10: In single-shot mode (`oneshot` = 1), `state_out` does not follow `raw_in` until `start` is pulsed. Let the clock edge that samples `start` high be E0, and let N be the window length: 1 for code 0, 3 for code 1, 5 for code 2. Then `ready` drops at E0 and rises after edge E0+2+N, together with a one-cycle end-of-comparison pulse on `irq_pulse` (when `irq_sel` = 3). The captured value then holds until the next start.
- R11: In continuous mode, `ready` rises 2+N clock edges after `en` is first sampled high.
- R12: `route_sel` drives `pin_out`: 0 gives low, 1 gives `raw_in` XOR `invert` with no clocking, 2 gives `state_out`, and 3 gives low.
- R13: Driving `en` low clears the state, the ready flag and the edge history on the next edge. No interrupt is issued while disabled, and `pin_out` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable; low clears all history |
| oneshot | input | 1 | 1 = single-shot mode, 0 = continuous |
| invert | input | 1 | Inverts the sampled comparator value |
| flt_len | input | 3 | Filter code: 0 none, 1 2-of-3, 2 3-of-5, others none |
| irq_sel | input | 2 | Interrupt event: 0 toggle, 1 rise, 2 fall, 3 end of comparison |
| route_sel | input | 2 | Pin source: 0 low, 1 raw, 2 conditioned, 3 low |
| start | input | 1 | Single-shot start strobe |
| raw_in | input | 1 | Unclocked comparator decision |
| state_out | output | 1 | Conditioned comparator state |
| irq_pulse | output | 1 | One-clock interrupt request |
| ready | output | 1 | Result valid flag |
| pin_out | output | 1 | Routed external output |

## Verification
The assertions rely on the configuration (`oneshot`, `irq_sel`, `flt_len`, `invert`, `route_sel`) staying fixed whenever `en` is high. This lets the edge, end-of-comparison and hold properties read the current select values as the ones that produced the output. The bench changes any setting only after first driving `en` low for a clock, and it drives `start` only in single-shot runs. The stimulus is applied on falling edges, so every synchronizer and vote latency is counted from a known rising edge.

// File: rtl/cmp_cond_pkg.sv
package cmp_cond_pkg;

  // Longest vote window supported by the filter.
  localparam int WIN_MAX = 5;

  localparam logic [2:0] FLT_NONE = 3'd0;
  localparam logic [2:0] FLT_MAJ3 = 3'd1;
  localparam logic [2:0] FLT_MAJ5 = 3'd2;

  typedef enum logic [1:0] {
    IRQ_TOGGLE = 2'd0,
    IRQ_RISE   = 2'd1,
    IRQ_FALL   = 2'd2,
    IRQ_EOC    = 2'd3
  } irq_sel_e;

  typedef enum logic [1:0] {
    RT_OFF  = 2'd0,
    RT_RAW  = 2'd1,
    RT_FILT = 2'd2,
    RT_RSVD = 2'd3
  } route_e;

  // Number of samples that take part in the vote; reserved codes use one.
  function automatic int win_len(input logic [2:0] code);
    case (code)
      FLT_MAJ3: return 3;
      FLT_MAJ5: return 5;
      default:  return 1;
    endcase
  endfunction

  // Majority over the newest win_len(code) samples; bit 0 is the newest.
  function automatic logic maj_vote(input logic [WIN_MAX-1:0] win,
                                    input logic [2:0] code);
    int len;
    int ones;
    len  = win_len(code);
    ones = 0;
    for (int i = 0; i < WIN_MAX; i++) begin
      if (i < len) ones += 32'(win[i]);
    end
    return (2 * ones) > len;
  endfunction

  // Event decode on the conditioned value versus its previous cycle.
  function automatic logic edge_hit(input logic [1:0] sel, input logic cur,
                                    input logic prev, input logic eoc);
    case (irq_sel_e'(sel))
      IRQ_TOGGLE: return cur ^ prev;
      IRQ_RISE:   return cur & ~prev;
      IRQ_FALL:   return ~cur & prev;
      default:    return eoc;
    endcase
  endfunction

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   ff <= '0;
        else if (clr) ff <= '0;
        else          ff <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   ff <= '0;
        else if (clr) ff <= '0;
        else          ff <= {ff[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = ff[STAGES-1];

endmodule

// File: rtl/cmp_vote_filter.sv
module cmp_vote_filter
  import cmp_cond_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       shift,
  input  logic       samp,
  input  logic [2:0] code,
  output logic       vote
);

  localparam int HIST_W = WIN_MAX - 1;

  logic [HIST_W-1:0]  hist;
  logic [WIN_MAX-1:0] win;

  // The current sample joins the stored history to form the window.
  assign win  = {hist, samp};
  assign vote = maj_vote(win, code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hist <= '0;
    else if (clr)   hist <= '0;
    else if (shift) hist <= {hist[HIST_W-2:0], samp};
  end

endmodule

// File: rtl/cmp_seq.sv
module cmp_seq #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             oneshot,
  input  logic             start,
  input  logic [CNT_W-1:0] fill,
  output logic             shift,
  output logic             capture,
  output logic             hist_clr,
  output logic             ready,
  output logic             eoc
);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             last;

  assign last     = (cnt == fill - CNT_W'(1));
  assign shift    = oneshot ? busy : 1'b1;
  assign capture  = oneshot ? (busy && last) : 1'b1;
  assign hist_clr = !en || (oneshot && start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      ready <= 1'b0;
      eoc   <= 1'b0;
    end else if (!en) begin
      busy  <= 1'b0;
      cnt   <= '0;
      ready <= 1'b0;
      eoc   <= 1'b0;
    end else if (oneshot) begin
      eoc <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        cnt   <= '0;
        ready <= 1'b0;
      end else if (busy) begin
        if (last) begin
          busy  <= 1'b0;
          ready <= 1'b1;
          eoc   <= 1'b1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end else begin
      busy <= 1'b0;
      eoc  <= 1'b0;
      if (!ready) begin
        if (last) ready <= 1'b1;
        else      cnt   <= cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/cmp_out_cond.sv
module cmp_out_cond
  import cmp_cond_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       oneshot,
  input  logic       invert,
  input  logic [2:0] flt_len,
  input  logic [1:0] irq_sel,
  input  logic [1:0] route_sel,
  input  logic       start,
  input  logic       raw_in,
  output logic       state_out,
  output logic       irq_pulse,
  output logic       ready,
  output logic       pin_out
);

  localparam int FILL_MAX = SYNC_STAGES + WIN_MAX;
  localparam int CNT_W    = $clog2(FILL_MAX + 1);

  logic             sync_q;
  logic             samp_w;
  logic             vote_w;
  logic             shift_w;
  logic             capture_w;
  logic             hist_clr_w;
  logic             eoc_w;
  logic [CNT_W-1:0] fill_w;
  logic             st_q;
  logic             st_prev;

  assign fill_w = CNT_W'(SYNC_STAGES + win_len(flt_len));

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!en),
    .d     (raw_in),
    .q     (sync_q)
  );

  assign samp_w = sync_q ^ invert;

  cmp_vote_filter u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (hist_clr_w),
    .shift (shift_w),
    .samp  (samp_w),
    .code  (flt_len),
    .vote  (vote_w)
  );

  cmp_seq #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .oneshot  (oneshot),
    .start    (start),
    .fill     (fill_w),
    .shift    (shift_w),
    .capture  (capture_w),
    .hist_clr (hist_clr_w),
    .ready    (ready),
    .eoc      (eoc_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= 1'b0;
      st_prev <= 1'b0;
    end else if (!en) begin
      st_q    <= 1'b0;
      st_prev <= 1'b0;
    end else begin
      if (capture_w) st_q <= vote_w;
      st_prev <= st_q;
    end
  end

  assign state_out = st_q;
  assign irq_pulse = en && edge_hit(irq_sel, st_q, st_prev, eoc_w && oneshot);

  always_comb begin
    pin_out = 1'b0;
    if (en) begin
      case (route_e'(route_sel))
        RT_RAW:  pin_out = raw_in ^ invert;
        RT_FILT: pin_out = st_q;
        default: pin_out = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/cmp_out_cond_chk.sv
module cmp_out_cond_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       oneshot,
  input logic       start,
  input logic [1:0] irq_sel,
  input logic [1:0] route_sel,
  input logic       state_out,
  input logic       irq_pulse,
  input logic       ready,
  input logic       pin_out
);

  // R7
  toggle_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse && irq_sel == 2'd0) |-> (state_out != $past(state_out)));

  // R8
  rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse && irq_sel == 2'd1) |-> (state_out && !$past(state_out)));

  // R8
  fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse && irq_sel == 2'd2) |-> (!state_out && $past(state_out)));

  // R9
  no_eoc_continuous_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oneshot && irq_sel == 2'd3) |-> !irq_pulse);

  // R10
  eoc_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse && irq_sel == 2'd3) |-> (ready && !$past(ready)));

  // R10
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && oneshot && ready && !start) |=> $stable(state_out));

  // R12
  route_filtered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && route_sel == 2'd2) |-> (pin_out == state_out));

  // R13
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!irq_pulse && !pin_out));

  // R13
  off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!ready && !state_out));

endmodule

bind cmp_out_cond cmp_out_cond_chk u_chk (.*);

// File: tb/cmp_out_cond_bench.sv
module cmp_out_cond_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       oneshot = 1'b0;
  logic       invert = 1'b0;
  logic [2:0] flt_len = 3'd0;
  logic [1:0] irq_sel = 2'd0;
  logic [1:0] route_sel = 2'd0;
  logic       start = 1'b0;
  logic       raw_in = 1'b0;
  logic       state_out, irq_pulse, ready, pin_out;

  int n_chk = 0;
  int n_bad = 0;
  int irq_cnt = 0;

  always #4 clk = ~clk;

  cmp_out_cond u_cmp_out_cond (
    .clk(clk), .rst_n(rst_n), .en(en), .oneshot(oneshot), .invert(invert),
    .flt_len(flt_len), .irq_sel(irq_sel), .route_sel(route_sel),
    .start(start), .raw_in(raw_in), .state_out(state_out),
    .irq_pulse(irq_pulse), .ready(ready), .pin_out(pin_out)
  );

  // Interrupt pulses counted 2 ns after each rising edge.
  always @(posedge clk) begin
    #2;
    if (irq_pulse) irq_cnt++;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input bit os, input bit inv, input logic [2:0] fl,
                     input logic [1:0] is, input logic [1:0] rt);
    en = 1'b0;
    raw_in = 1'b0;
    start = 1'b0;
    step(1);
    oneshot = os; invert = inv; flt_len = fl; irq_sel = is; route_sel = rt;
    en = 1'b1;
    step(10);
  endtask

  task automatic t_reset;
    step(2);
    rst_n = 1'b1;
    step(2);
    chk("R1 state", state_out, 0);
    chk("R1 ready", ready, 0);
    chk("R1 irq", irq_pulse, 0);
    chk("R1 pin", pin_out, 0);
  endtask

  task automatic t_nofilt;
    int base;
    cfg(0, 0, 3'd0, 2'd0, 2'd2);
    base = irq_cnt;
    raw_in = 1'b1;
    step(2);
    chk("R2 before", state_out, 0);
    step(1);
    chk("R2 after", state_out, 1);
    chk("R12 filtered route", pin_out, 1);
    step(2);
    chk("R7 one pulse", irq_cnt - base, 1);
  endtask

  task automatic t_maj3;
    cfg(0, 0, 3'd1, 2'd0, 2'd2);
    raw_in = 1'b1; step(1); raw_in = 1'b0;
    step(8);
    chk("R3 glitch", state_out, 0);
    raw_in = 1'b1;
    step(3);
    chk("R3 before", state_out, 0);
    step(1);
    chk("R3 after", state_out, 1);
  endtask

  task automatic t_maj5;
    cfg(0, 0, 3'd2, 2'd0, 2'd2);
    raw_in = 1'b1; step(2); raw_in = 1'b0;
    step(10);
    chk("R4 glitch", state_out, 0);
    raw_in = 1'b1;
    step(4);
    chk("R4 before", state_out, 0);
    step(1);
    chk("R4 after", state_out, 1);
  endtask

  task automatic t_reserved;
    int base;
    cfg(0, 0, 3'd5, 2'd0, 2'd2);
    raw_in = 1'b1;
    step(3);
    chk("R5 latency", state_out, 1);
    step(4);
    base = irq_cnt;
    raw_in = 1'b0; step(1); raw_in = 1'b1;
    step(6);
    chk("R5 glitch passes", irq_cnt - base, 2);
    chk("R5 final", state_out, 1);
  endtask

  task automatic t_invert;
    cfg(0, 1, 3'd0, 2'd0, 2'd1);
    chk("R6 low in", state_out, 1);
    raw_in = 1'b1;
    #1;
    chk("R12 raw route inverted", pin_out, 0);
    step(3);
    chk("R6 high in", state_out, 0);
  endtask

  task automatic t_toggle;
    int base;
    cfg(0, 0, 3'd1, 2'd0, 2'd2);
    base = irq_cnt;
    raw_in = 1'b1; step(6);
    raw_in = 1'b0; step(6);
    chk("R7 two toggles", irq_cnt - base, 2);
  endtask

  task automatic t_edges;
    int base;
    cfg(0, 0, 3'd0, 2'd1, 2'd2);
    base = irq_cnt;
    raw_in = 1'b1; step(5);
    chk("R8 rise seen", irq_cnt - base, 1);
    raw_in = 1'b0; step(5);
    chk("R8 fall ignored", irq_cnt - base, 1);
    cfg(0, 0, 3'd0, 2'd2, 2'd2);
    base = irq_cnt;
    raw_in = 1'b1; step(5);
    chk("R8 rise ignored", irq_cnt - base, 0);
    raw_in = 1'b0; step(5);
    chk("R8 fall seen", irq_cnt - base, 1);
  endtask

  task automatic t_eoc_cont;
    int base;
    cfg(0, 0, 3'd0, 2'd3, 2'd2);
    base = irq_cnt;
    raw_in = 1'b1; step(5);
    raw_in = 1'b0; step(5);
    chk("R9 no eoc", irq_cnt - base, 0);
  endtask

  task automatic t_oneshot;
    int base;
    cfg(1, 0, 3'd1, 2'd3, 2'd2);
    raw_in = 1'b1;
    step(10);
    chk("R10 idle ready", ready, 0);
    chk("R10 idle state", state_out, 0);
    base = irq_cnt;
    start = 1'b1; step(1); start = 1'b0;
    step(4);
    chk("R10 not yet ready", ready, 0);
    step(1);
    chk("R10 ready", ready, 1);
    chk("R10 eoc pulse", irq_pulse, 1);
    chk("R10 captured", state_out, 1);
    raw_in = 1'b0;
    step(10);
    chk("R10 held", state_out, 1);
    chk("R10 single eoc", irq_cnt - base, 1);
    start = 1'b1; step(1); start = 1'b0;
    chk("R10 ready drops", ready, 0);
    step(5);
    chk("R10 second ready", ready, 1);
    chk("R10 second value", state_out, 0);
  endtask

  task automatic t_cont_ready;
    en = 1'b0; step(1);
    oneshot = 1'b0; flt_len = 3'd2;
    en = 1'b1;
    step(6);
    chk("R11 not ready", ready, 0);
    step(1);
    chk("R11 ready", ready, 1);
  endtask

  task automatic t_route;
    cfg(0, 0, 3'd0, 2'd0, 2'd0);
    raw_in = 1'b1; step(4);
    chk("R12 off", pin_out, 0);
    cfg(0, 0, 3'd0, 2'd0, 2'd1);
    raw_in = 1'b1; #1;
    chk("R12 raw high", pin_out, 1);
    raw_in = 1'b0; #1;
    chk("R12 raw low", pin_out, 0);
    cfg(0, 0, 3'd0, 2'd0, 2'd3);
    raw_in = 1'b1; step(4);
    chk("R12 reserved", pin_out, 0);
  endtask

  task automatic t_disable;
    int base;
    cfg(0, 0, 3'd0, 2'd0, 2'd2);
    raw_in = 1'b1; step(5);
    chk("R13 pre state", state_out, 1);
    base = irq_cnt;
    en = 1'b0;
    step(1);
    chk("R13 state", state_out, 0);
    chk("R13 ready", ready, 0);
    chk("R13 pin", pin_out, 0);
    raw_in = 1'b0; step(3); raw_in = 1'b1; step(3);
    chk("R13 no irq", irq_cnt - base, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_nofilt();
    t_maj3();
    t_maj5();
    t_reserved();
    t_invert();
    t_toggle();
    t_edges();
    t_eoc_cont();
    t_oneshot();
    t_cont_ready();
    t_route();
    t_disable();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

endmodule